// File: doc/BRIEF.md
# Scanline Timing and Display Status Generator

This block paces the picture. It counts clock cycles inside each scanline and scanlines inside each frame. It keeps a visible line counter and sets the horizontal and vertical blanking flags. At the points in the line where other logic must act, it issues single-cycle interrupt requests and DMA trigger strobes.

Two processors share the one timing base. Each processor has its own 16-bit status/control word. That word holds the blanking flags, a line-match flag, three interrupt enables and a 9-bit line-match value. The match value is split across the word: its top bit sits below the byte that holds its low eight bits.

One write port reaches both status words and the line counter. A write to the line counter is held back. It takes effect at the next line start, where it replaces the usual increment. When the frame wraps to its first line, the counter is still forced to zero.

Top module: `vid_timing_gen`

## Requirements
- R1: A line lasts LINE_CYCLES clocks (default 2130). Status bit 1 (horizontal blank) becomes 1 exactly HBL_CYCLES clocks (default 1584) after a line start. It returns to 0 at the following line start.
- R2: At every line start the line counter advances by one. After FRAME_LINES lines (default 263), the frame restarts and the counter reads 0.
- R3: Status bit 0 (vertical blank) is set at the line start where the counter becomes 192. It is cleared at the line start where the counter becomes 262. At every other line start it keeps its value.
- R4: At every line start, status bit 2 is set if the new counter value equals that word's match value and is cleared otherwise. A match also pulses that processor's match interrupt when bit 5 is set.
- R5: The vertical-blank interrupt pulses at the line start where the counter becomes 192, if bit 3 is set. The horizontal-blank interrupt pulses at each horizontal-blank start, if bit 4 is set. Each interrupt is a one-cycle pulse, gated by the enables held before that clock edge.
- R6: A status write loads only the written bits under mask 0xFFB8. Bits 0, 1, 2 and 6 keep their current state. A write with select value 3 changes nothing.
- R7: The 9-bit match value is written bit 7 as its bit 8, with written bits 15:8 as its bits 7:0.
- R8: A write to the line counter (select 2, data bits 8:0) is loaded at the next line start in place of the increment, and the counter holds its value until then. The first line of a frame still forces 0. A write made on the same clock as a line start applies at the line start after that one.
- R9: The horizontal-blank DMA strobe pulses at a horizontal-blank start only while the counter is below 192. The vertical-blank DMA strobe pulses at the line start where the counter becomes 192.
- R10: The two status words are independent. Select 0 writes word 0 and select 1 writes word 1. Each compares against its own match value and uses its own enables.
- R11: After reset the counter, both status words and all pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 and 1 status words, 2 line counter, 3 none |
| wr_data | input | 16 | Write data |
| line_cnt | output | CNT_W | Current line counter |
| stat | output | NUM_STAT x 16 | Status/control words, one per processor |
| irq_vbl | output | NUM_STAT | Vertical-blank interrupt pulses |
| irq_hbl | output | NUM_STAT | Horizontal-blank interrupt pulses |
| irq_match | output | NUM_STAT | Line-match interrupt pulses |
| dma_hbl | output | 1 | Horizontal-blank DMA strobe |
| dma_vbl | output | 1 | Vertical-blank DMA strobe |

## Verification
Two pairs of events can land on the same clock edge. A status write can arrive on a line-start edge, and a line-counter write can arrive on a line-start edge. The bench waits until the cycle before a line start and issues each kind of write there. It pairs the status write with a match value and enables that change the outcome. A per-cycle reference model is built from the requirements. It judges that the flags follow the timing, that the enabled fields take the written value, that the interrupt uses the enables held before the edge, and that the delayed counter load waits one more line. Random writes of every select and of line counts around 191, 192, 261 and 262 cover the remaining overlaps.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
   // status word bit positions
   localparam int ST_VBL      = 0;
   localparam int ST_HBL      = 1;
   localparam int ST_MATCH    = 2;
   localparam int ST_VBL_EN   = 3;
   localparam int ST_HBL_EN   = 4;
   localparam int ST_MATCH_EN = 5;

   // bits a write may load, and bits a write leaves alone
   localparam logic [15:0] WR_LOAD_MASK = 16'hFFB8;
   localparam logic [15:0] WR_KEEP_MASK = 16'h0047;

   typedef struct packed {
      logic line_start;
      logic hbl_start;
   } vtg_evt_t;
endpackage

// File: rtl/vtg_hcount.sv
module vtg_hcount
   import vtg_pkg::*;
#(
   parameter int LINE_CYCLES = 2130,
   parameter int HBL_CYCLES  = 1584
)(
   input  logic     clk,
   input  logic     rst_n,
   output vtg_evt_t evt
);
   localparam int HW = (LINE_CYCLES > 2) ? $clog2(LINE_CYCLES) : 1;
   localparam logic [HW-1:0] LAST_CYC = HW'(LINE_CYCLES - 1);
   localparam logic [HW-1:0] HBL_CYC  = HW'(HBL_CYCLES - 1);

   generate
      if (LINE_CYCLES < 3) begin : g_bad_line
         $error("LINE_CYCLES must be at least 3");
      end
      if (HBL_CYCLES < 1 || HBL_CYCLES >= LINE_CYCLES) begin : g_bad_hbl
         $error("HBL_CYCLES must lie in 1..LINE_CYCLES-1");
      end
   endgenerate

   logic [HW-1:0] hcnt;

   always_comb begin
      evt.line_start = (hcnt == LAST_CYC);
      evt.hbl_start  = (hcnt == HBL_CYC);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              hcnt <= '0;
      else if (evt.line_start) hcnt <= '0;
      else                     hcnt <= hcnt + 1'b1;
   end

   AST_HBL_NOT_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      evt.line_start |=> !evt.hbl_start || (HBL_CYCLES == 1)) else $error("hbl at wrap"); // R1
endmodule

// File: rtl/vtg_vcount.sv
module vtg_vcount
   import vtg_pkg::*;
#(
   parameter int FRAME_LINES = 263,
   parameter int VBL_LINE    = 192,
   parameter int CNT_W       = 9
)(
   input  logic             clk,
   input  logic             rst_n,
   input  vtg_evt_t         evt,
   input  logic             wr_vc,
   input  logic [CNT_W-1:0] wr_val,
   output logic [CNT_W-1:0] vcount,
   output logic [CNT_W-1:0] vc_next,
   output logic             dma_hbl,
   output logic             dma_vbl
);
   localparam int IW = $clog2(FRAME_LINES);
   localparam logic [IW-1:0]    LAST_IDX = IW'(FRAME_LINES - 1);
   localparam logic [CNT_W-1:0] VBL_VAL  = CNT_W'(VBL_LINE);

   generate
      if (FRAME_LINES < 2) begin : g_bad_frame
         $error("FRAME_LINES must be at least 2");
      end
   endgenerate

   logic [IW-1:0]    line_idx;
   logic             pend_vld;
   logic [CNT_W-1:0] pend_val;
   logic             wrap;

   always_comb begin
      wrap    = (line_idx == LAST_IDX);
      vc_next = vcount;
      if (evt.line_start) begin
         if (wrap)          vc_next = '0;
         else if (pend_vld) vc_next = pend_val;
         else               vc_next = vcount + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_idx <= '0;
         vcount   <= '0;
         pend_vld <= 1'b0;
         pend_val <= '0;
         dma_hbl  <= 1'b0;
         dma_vbl  <= 1'b0;
      end else begin
         if (evt.line_start) line_idx <= wrap ? '0 : line_idx + 1'b1;
         vcount  <= vc_next;
         dma_hbl <= evt.hbl_start && (vcount < VBL_VAL);
         dma_vbl <= evt.line_start && (vc_next == VBL_VAL);
         if (wr_vc) begin
            pend_vld <= 1'b1;
            pend_val <= wr_val;
         end else if (evt.line_start) begin
            pend_vld <= 1'b0;
         end
      end
   end

   AST_FRAME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.line_start && wrap) |=> (vcount == '0)) else $error("frame wrap"); // R2
   AST_PEND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.line_start && !wr_vc) |=> !pend_vld) else $error("pending kept"); // R8
   AST_VBL_DMA_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      dma_vbl |-> (vcount == VBL_VAL)) else $error("vbl dma line"); // R9
   AST_HBL_DMA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      dma_hbl |-> (vcount < VBL_VAL)) else $error("hbl dma range"); // R9
endmodule

// File: rtl/vtg_status.sv
module vtg_status
   import vtg_pkg::*;
#(
   parameter int VBL_LINE = 192,
   parameter int VBL_END  = 262,
   parameter int CNT_W    = 9
)(
   input  logic             clk,
   input  logic             rst_n,
   input  vtg_evt_t         evt,
   input  logic [CNT_W-1:0] vc_next,
   input  logic             wr_en,
   input  logic [15:0]      wr_data,
   output logic [15:0]      stat,
   output logic             irq_vbl,
   output logic             irq_hbl,
   output logic             irq_match
);
   localparam logic [CNT_W-1:0] VBL_VAL = CNT_W'(VBL_LINE);
   localparam logic [CNT_W-1:0] END_VAL = CNT_W'(VBL_END);

   logic [CNT_W-1:0] match_val;
   logic [15:0]      stat_n;
   logic             hit;

   generate
      if (CNT_W == 9) begin : g_match9
         assign match_val = {stat[7], stat[15:8]};
      end else if (CNT_W == 8) begin : g_match8
         assign match_val = stat[15:8];
      end else begin : g_bad_w
         $error("CNT_W must be 8 or 9");
         assign match_val = '0;
      end
   endgenerate

   always_comb begin
      hit    = (vc_next == match_val);
      stat_n = stat;
      if (evt.line_start) begin
         stat_n[ST_HBL]   = 1'b0;
         stat_n[ST_MATCH] = hit;
         if (vc_next == VBL_VAL)      stat_n[ST_VBL] = 1'b1;
         else if (vc_next == END_VAL) stat_n[ST_VBL] = 1'b0;
      end
      if (evt.hbl_start) stat_n[ST_HBL] = 1'b1;
      if (wr_en) stat_n = (wr_data & WR_LOAD_MASK) | (stat_n & WR_KEEP_MASK);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat      <= '0;
         irq_vbl   <= 1'b0;
         irq_hbl   <= 1'b0;
         irq_match <= 1'b0;
      end else begin
         stat      <= stat_n;
         irq_vbl   <= evt.line_start && (vc_next == VBL_VAL) && stat[ST_VBL_EN];
         irq_hbl   <= evt.hbl_start && stat[ST_HBL_EN];
         irq_match <= evt.line_start && hit && stat[ST_MATCH_EN];
      end
   end

   AST_HBL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      evt.line_start |=> !stat[ST_HBL]) else $error("hbl not cleared"); // R1
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt.line_start && !evt.hbl_start) |=> (stat[2:0] == $past(stat[2:0])))
      else $error("flag moved"); // R6
   AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq_match |-> stat[ST_MATCH]) else $error("match irq without flag"); // R4
   AST_HBL_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq_hbl |-> stat[ST_HBL]) else $error("hbl irq without flag"); // R5
   AST_VBL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_vbl |=> !irq_vbl) else $error("vbl irq stuck"); // R5
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
   import vtg_pkg::*;
#(
   parameter int LINE_CYCLES = 2130,
   parameter int HBL_CYCLES  = 1584,
   parameter int FRAME_LINES = 263,
   parameter int VBL_LINE    = 192,
   parameter int VBL_END     = 262,
   parameter int CNT_W       = 9,
   parameter int NUM_STAT    = 2
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [1:0]               wr_sel,
   input  logic [15:0]              wr_data,
   output logic [CNT_W-1:0]         line_cnt,
   output logic [NUM_STAT-1:0][15:0] stat,
   output logic [NUM_STAT-1:0]      irq_vbl,
   output logic [NUM_STAT-1:0]      irq_hbl,
   output logic [NUM_STAT-1:0]      irq_match,
   output logic                     dma_hbl,
   output logic                     dma_vbl
);
   localparam logic [1:0] SEL_VC = 2'(NUM_STAT);

   generate
      if (NUM_STAT < 1 || NUM_STAT > 3) begin : g_bad_num
         $error("NUM_STAT must lie in 1..3");
      end
      if (VBL_END >= (1 << CNT_W) || VBL_LINE >= VBL_END) begin : g_bad_vbl
         $error("blanking lines do not fit the counter");
      end
   endgenerate

   vtg_evt_t         evt;
   logic [CNT_W-1:0] vc_next;

   vtg_hcount #(
      .LINE_CYCLES (LINE_CYCLES),
      .HBL_CYCLES  (HBL_CYCLES)
   ) u_hcount (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt)
   );

   vtg_vcount #(
      .FRAME_LINES (FRAME_LINES),
      .VBL_LINE    (VBL_LINE),
      .CNT_W       (CNT_W)
   ) u_vcount (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .wr_vc   (wr_en && (wr_sel == SEL_VC)),
      .wr_val  (wr_data[CNT_W-1:0]),
      .vcount  (line_cnt),
      .vc_next (vc_next),
      .dma_hbl (dma_hbl),
      .dma_vbl (dma_vbl)
   );

   generate
      for (genvar k = 0; k < NUM_STAT; k++) begin : g_stat
         vtg_status #(
            .VBL_LINE (VBL_LINE),
            .VBL_END  (VBL_END),
            .CNT_W    (CNT_W)
         ) u_status (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt       (evt),
            .vc_next   (vc_next),
            .wr_en     (wr_en && (wr_sel == 2'(k))),
            .wr_data   (wr_data),
            .stat      (stat[k]),
            .irq_vbl   (irq_vbl[k]),
            .irq_hbl   (irq_hbl[k]),
            .irq_match (irq_match[k])
         );
      end
   endgenerate
endmodule

// File: tb/test_vid_timing_gen.sv
module test_vid_timing_gen;
   localparam int LC = 20;
   localparam int HC = 14;
   localparam int FL = 263;
   localparam int VB = 192;
   localparam int VE = 262;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [15:0] wr_data = 16'd0;
   logic [8:0]  line_cnt;
   logic [1:0][15:0] stat;
   logic [1:0]  irq_vbl, irq_hbl, irq_match;
   logic        dma_hbl, dma_vbl;

   vid_timing_gen #(.LINE_CYCLES(LC), .HBL_CYCLES(HC), .FRAME_LINES(FL),
                    .VBL_LINE(VB), .VBL_END(VE), .CNT_W(9), .NUM_STAT(2)) i_vid_timing_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .line_cnt(line_cnt), .stat(stat), .irq_vbl(irq_vbl), .irq_hbl(irq_hbl),
      .irq_match(irq_match), .dma_hbl(dma_hbl), .dma_vbl(dma_vbl));

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // reference model, built from the requirements
   int mh, midx;
   logic [8:0] mvc, mpval;
   bit mpv;
   logic [15:0] ms [2];
   bit mi_v [2], mi_h [2], mi_m [2];
   bit md_h, md_v;

   always @(posedge clk) begin : ref_model
      bit ls, hs;
      logic [8:0] nvc, mval;
      logic [15:0] f;
      if (!rst_n) begin
         mh = 0; midx = 0; mvc = '0; mpval = '0; mpv = 1'b0; md_h = 1'b0; md_v = 1'b0;
         for (int k = 0; k < 2; k++) begin
            ms[k] = '0; mi_v[k] = 1'b0; mi_h[k] = 1'b0; mi_m[k] = 1'b0;
         end
      end else begin
         ls = (mh == LC - 1);
         hs = (mh == HC - 1);
         nvc = mvc;
         if (ls) begin
            midx = (midx == FL - 1) ? 0 : midx + 1;
            nvc = (midx == 0) ? 9'd0 : (mpv ? mpval : mvc + 9'd1);
         end
         md_h = hs && (mvc < 9'(VB));
         md_v = ls && (nvc == 9'(VB));
         for (int k = 0; k < 2; k++) begin
            mval = {ms[k][7], ms[k][15:8]};
            mi_v[k] = ls && (nvc == 9'(VB)) && ms[k][3];
            mi_h[k] = hs && ms[k][4];
            mi_m[k] = ls && (nvc == mval) && ms[k][5];
            f = ms[k];
            if (ls) begin
               f[1] = 1'b0;
               f[2] = (nvc == mval);
               if (nvc == 9'(VB)) f[0] = 1'b1;
               else if (nvc == 9'(VE)) f[0] = 1'b0;
            end
            if (hs) f[1] = 1'b1;
            if (wr_en && wr_sel == 2'(k)) f = (wr_data & 16'hFFB8) | (f & 16'h0047);
            ms[k] = f;
         end
         if (wr_en && wr_sel == 2'd2) begin
            mpv = 1'b1; mpval = wr_data[8:0];
         end else if (ls) begin
            mpv = 1'b0;
         end
         mvc = nvc;
         mh = ls ? 0 : mh + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R2 R8 line counter", 32'(line_cnt), 32'(mvc));
      for (int k = 0; k < 2; k++) begin
         chk("R3 vblank flag", 32'(stat[k][0]), 32'(ms[k][0]));
         chk("R1 hblank flag", 32'(stat[k][1]), 32'(ms[k][1]));
         chk("R4 R7 match flag", 32'(stat[k][2]), 32'(ms[k][2]));
         chk("R6 R10 written fields", 32'(stat[k]), 32'(ms[k]));
         chk("R5 vblank irq", 32'(irq_vbl[k]), 32'(mi_v[k]));
         chk("R5 hblank irq", 32'(irq_hbl[k]), 32'(mi_h[k]));
         chk("R4 match irq", 32'(irq_match[k]), 32'(mi_m[k]));
      end
      chk("R9 hblank dma", 32'(dma_hbl), 32'(md_h));
      chk("R9 vblank dma", 32'(dma_vbl), 32'(md_v));
   endtask

   // one clock: drive at negedge, compare at the following negedge
   task automatic step(input bit we, input logic [1:0] sel, input logic [15:0] d);
      wr_en = we; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      compare_all();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 2'd0, 16'd0);
   endtask

   task automatic to_line_end();
      while (mh != LC - 1) step(1'b0, 2'd0, 16'd0);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11 reset line counter", 32'(line_cnt), 32'd0);
      chk("R11 reset status", 32'(stat), 32'd0);
      chk("R11 reset pulses", 32'({irq_vbl, irq_hbl, irq_match, dma_hbl, dma_vbl}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      compare_all();

      // R6 R7 R10: mask test and split match values (word0 line 5, word1 line 300)
      step(1'b1, 2'd0, 16'h057F);
      step(1'b1, 2'd1, 16'h2CFF);
      chk("R6 keep bits", 32'(stat[0] & 16'h0047), 32'd0);
      chk("R7 match value word1", 32'({stat[1][7], stat[1][15:8]}), 32'd300);
      step(1'b1, 2'd3, 16'hFFFF);            // R6 select 3 ignored
      idle(LC * 12);

      // R8: delayed counter load mid-line, then at a line-start edge
      idle(5);
      step(1'b1, 2'd2, 16'd190);
      chk("R8 write held", 32'(line_cnt), 32'(mvc));
      idle(LC * 4);
      to_line_end();
      step(1'b1, 2'd2, 16'd299);              // lands with a line start: waits one line
      idle(LC * 3);

      // R4 R5 collision: status write on a line-start edge changing enables and match
      to_line_end();
      step(1'b1, 2'd1, 16'h2C80);             // enables cleared at line start for 300
      idle(LC * 2);
      step(1'b1, 2'd2, 16'd259);
      idle(LC * 6);

      // random phase with a few frames of mixed writes
      for (int i = 0; i < FL * LC * 3; i++) begin
         if ($urandom_range(63) == 0) begin
            logic [1:0] s;
            logic [15:0] d;
            s = 2'($urandom_range(3));
            d = 16'($urandom);
            if (s == 2'd2) begin
               case ($urandom_range(3))
                  0: d = 16'(191 + $urandom_range(2));
                  1: d = 16'(261 + $urandom_range(2));
                  2: d = 16'($urandom_range(511));
                  default: d = 16'($urandom_range(10));
               endcase
            end else if (s != 2'd3 && $urandom_range(1) == 0) begin
               d[15:8] = 8'(mvc + 9'd2);
               d[7] = mvc[8];
            end
            step(1'b1, s, d);
         end else begin
            step(1'b0, 2'd0, 16'd0);
         end
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 190000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule